// File: doc/BRIEF.md
# Dual-Channel Indirect Register Port

This block is the host-facing register front end of a two-channel serial controller. Each channel offers the host only two byte-wide locations: a command location and a data location. Most of the sixteen write registers and the readable status registers of a channel can only be reached indirectly. The host first writes a register number to the command location, and the next command-location access then goes to that register. The serial shifters are outside this block. They reach it only through status inputs (line status, special-condition status, loop status, received byte, pending interrupts) and through the stored register bytes that the block drives out.

Every access is a single-cycle synchronous strobe. The read data is combinational during a read strobe, and register and pointer updates take effect at the clock edge that closes the access. The interrupt-vector and master-control registers exist once and are shared by both channels. The interrupt-pending view answers only on channel A. Any command-location read puts the pointer back to idle, so two reads in a row always resynchronise software. Channel A is channel index 0.

Top module: `dual_chan_regport`

## Requirements
- R1: After reset every stored register byte in `regFile` is zero, `txLoad` is low and both channel pointers are idle. An idle command read therefore returns that channel's `statusIn` byte.
- R2: While a channel is idle, a command write selects target register {bits[5:3]==3'b001, bits[2:0]}. Bits 2:0 give the low three bits, and the code 3'b001 in bits 5:3 adds 8, while any other code adds nothing. The byte itself is stored in slot 0. A nonzero target arms that channel only, and a zero target leaves it idle.
- R3: An idle command read returns `statusIn` of the addressed channel and changes no stored register.
- R4: When a channel is armed, its next command access (read or write) goes to the selected register, after which the pointer is idle again. A command read never leaves the pointer armed, so two consecutive command reads always end idle.
- R5: The data location is register 8. A data read returns `rxByteIn` of the channel and raises `rxPop` for that channel in the same cycle. A data write stores the byte in slot 8 and raises `txLoad` for that channel in the following cycle. Data accesses do not change the pointer, and register 8 reached through the pointer behaves identically.
- R6: Bytes written to registers 12 (low) and 13 (high) of the time constant are read back unchanged from read registers 12 and 13.
- R7: Read register 3 returns {2'b00, pendIn} on channel A (index 0) and 8'h00 on channel B.
- R8: Read register 15 returns the byte written to register 15 ANDed with 8'hFA, so bits 0 and 2 always read zero.
- R9: Registers 2 (vector) and 9 (master control) have one copy each. A write through either channel appears in slots 2 and 9 of both channels, and read register 2 returns the vector on both channels.
- R10: Read register 1 returns `specialIn`, and read register 10 returns `loopStatIn`. Read registers 4, 5, 6, 7, 9, 11 and 14 return 8'h00, even where a byte was written to the same number.
- R11: If `hostWr` and `hostRd` are both high, the access is a write, and `hostRdata` reads 8'h00 whenever no read is taking place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostChan | input | 1 | Channel select, 0 = channel A, 1 = channel B |
| hostData | input | 1 | Location select, 0 = command, 1 = data |
| hostWr | input | 1 | Write strobe |
| hostRd | input | 1 | Read strobe |
| hostWdata | input | 8 | Write byte |
| hostRdata | output | 8 | Read byte, valid during a read strobe |
| statusIn | input | 16 | Line status per channel (byte ch at bits 8*ch) |
| specialIn | input | 16 | Special-condition status per channel |
| loopStatIn | input | 16 | Loop status per channel |
| rxByteIn | input | 16 | Head of receive buffer per channel |
| pendIn | input | 6 | Pending interrupt bits of both channels |
| rxPop | output | 2 | Receive byte consumed, per channel |
| txLoad | output | 2 | Transmit buffer loaded, per channel |
| regFile | output | 256 | Write register bytes, slot r of channel ch at bits 8*(16*ch+r) |

## Verification
The pointer protocol is driven with low targets, with targets raised by the 3'b001 code, with other codes in bits 5:3 that must not raise the target, and with a zero target that must not arm. Together these separate a correct index build from one that ignores or misreads the command code. Resync is tested with read pairs after a pointer has been armed, and a second channel is accessed while the first is armed, which shows whether the pointer state is kept per channel. The shared registers are written through one channel and read through the other, and channel-restricted and unimplemented read numbers are read after bytes have been written to the same numbers, which separates a real zero from a leaked write value.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int CHANS  = 2;
  localparam int BYTE_W = 8;
  localparam int REGS   = 16;
  localparam int PEND_W = 6;
  localparam int IDX_W  = $clog2(REGS);
  localparam int CH_W   = $clog2(CHANS);

  localparam logic [CH_W-1:0]  CH_A      = '0;
  localparam logic [IDX_W-1:0] IDX_STAT  = 4'd0;
  localparam logic [IDX_W-1:0] IDX_SPEC  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_VEC   = 4'd2;
  localparam logic [IDX_W-1:0] IDX_PEND  = 4'd3;
  localparam logic [IDX_W-1:0] IDX_DATA  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_MCTL  = 4'd9;
  localparam logic [IDX_W-1:0] IDX_LOOP  = 4'd10;
  localparam logic [IDX_W-1:0] IDX_TCLO  = 4'd12;
  localparam logic [IDX_W-1:0] IDX_TCHI  = 4'd13;
  localparam logic [IDX_W-1:0] IDX_IEN   = 4'd15;
  localparam logic [2:0]       CODE_HIGH = 3'b001;
  localparam logic [BYTE_W-1:0] IEN_MASK = 8'hFA;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic [CH_W-1:0]  chan;
    logic [IDX_W-1:0] idx;
  } accStrobe_t;
endpackage

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import regport_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [CH_W-1:0] hostChan,
  input  logic            hostData,
  input  logic            hostWr,
  input  logic            hostRd,
  input  logic [5:0]      cmdBits,
  output accStrobe_t      acc
);
  logic [CHANS-1:0] armedQ;
  logic [IDX_W-1:0] ptrQ [CHANS];
  logic [IDX_W-1:0] ptrNext;
  logic             cmdAcc;
  logic             rdOnly;

  assign cmdAcc  = (hostWr | hostRd) & ~hostData;
  assign rdOnly  = hostRd & ~hostWr;
  assign ptrNext = {cmdBits[5:3] == CODE_HIGH, cmdBits[2:0]};

  always_comb begin
    acc.wr   = hostWr;
    acc.rd   = rdOnly;
    acc.chan = hostChan;
    if (hostData)                acc.idx = IDX_DATA;
    else if (armedQ[hostChan])   acc.idx = ptrQ[hostChan];
    else                         acc.idx = IDX_STAT;
  end

  for (genvar ch = 0; ch < CHANS; ch++) begin : g_ptr
    logic hit;
    assign hit = cmdAcc && (hostChan == CH_W'(ch));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        armedQ[ch] <= 1'b0;
        ptrQ[ch]   <= '0;
      end else if (hit) begin
        if (armedQ[ch]) begin
          armedQ[ch] <= 1'b0;
          ptrQ[ch]   <= '0;
        end else if (hostWr) begin
          ptrQ[ch]   <= ptrNext;
          armedQ[ch] <= (ptrNext != '0);
        end
      end
    end

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hit && hostWr && !armedQ[ch] && cmdBits[2:0] != 3'b000)
      |=> (armedQ[ch] && ptrQ[ch][2:0] == $past(cmdBits[2:0])));

    // R4
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hit && armedQ[ch]) |=> !armedQ[ch]);

    // R4
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hit && !hostWr) |=> !armedQ[ch]);
  end

  // R5
  data_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostData && (hostWr || hostRd)) |=> $stable(armedQ));
endmodule

// File: rtl/regport_dp.sv
module regport_dp
  import regport_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  accStrobe_t                   acc,
  input  logic [BYTE_W-1:0]            hostWdata,
  input  logic [CHANS*BYTE_W-1:0]      statusIn,
  input  logic [CHANS*BYTE_W-1:0]      specialIn,
  input  logic [CHANS*BYTE_W-1:0]      loopStatIn,
  input  logic [CHANS*BYTE_W-1:0]      rxByteIn,
  input  logic [PEND_W-1:0]            pendIn,
  output logic [BYTE_W-1:0]            hostRdata,
  output logic [CHANS-1:0]             rxPop,
  output logic [CHANS-1:0]             txLoad,
  output logic [CHANS*REGS*BYTE_W-1:0] regFile
);
  logic [BYTE_W-1:0] vecQ, mctlQ;
  logic [BYTE_W-1:0] ownSlot;
  int                chIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ  <= '0;
      mctlQ <= '0;
    end else if (acc.wr) begin
      if (acc.idx == IDX_VEC)  vecQ  <= hostWdata;
      if (acc.idx == IDX_MCTL) mctlQ <= hostWdata;
    end
  end

  for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
    for (genvar r = 0; r < REGS; r++) begin : g_slot
      localparam int BASE = (ch * REGS + r) * BYTE_W;
      if (r == int'(IDX_VEC)) begin : g_vec
        assign regFile[BASE +: BYTE_W] = vecQ;
      end else if (r == int'(IDX_MCTL)) begin : g_mctl
        assign regFile[BASE +: BYTE_W] = mctlQ;
      end else begin : g_own
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
          if (!rstN) q <= '0;
          else if (acc.wr && acc.chan == CH_W'(ch) && acc.idx == IDX_W'(r))
            q <= hostWdata;
        end
        assign regFile[BASE +: BYTE_W] = q;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) txLoad[ch] <= 1'b0;
      else       txLoad[ch] <= acc.wr && acc.chan == CH_W'(ch) && acc.idx == IDX_DATA;
    end

    assign rxPop[ch] = acc.rd && acc.chan == CH_W'(ch) && acc.idx == IDX_DATA;
  end

  assign chIdx   = int'(acc.chan);
  assign ownSlot = regFile[(chIdx * REGS + int'(acc.idx)) * BYTE_W +: BYTE_W];

  always_comb begin
    hostRdata = '0;
    if (acc.rd) begin
      case (acc.idx)
        IDX_STAT: hostRdata = statusIn[chIdx*BYTE_W +: BYTE_W];
        IDX_SPEC: hostRdata = specialIn[chIdx*BYTE_W +: BYTE_W];
        IDX_VEC:  hostRdata = vecQ;
        IDX_PEND: hostRdata = (acc.chan == CH_A) ? BYTE_W'(pendIn) : '0;
        IDX_DATA: hostRdata = rxByteIn[chIdx*BYTE_W +: BYTE_W];
        IDX_LOOP: hostRdata = loopStatIn[chIdx*BYTE_W +: BYTE_W];
        IDX_TCLO, IDX_TCHI: hostRdata = ownSlot;
        IDX_IEN:  hostRdata = ownSlot & IEN_MASK;
        default:  hostRdata = '0;
      endcase
    end
  end

  // R7
  rr3_chanb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc.rd && acc.chan != CH_A && acc.idx == IDX_PEND) |-> hostRdata == '0);

  // R8
  ien_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc.rd && acc.idx == IDX_IEN) |-> (!hostRdata[0] && !hostRdata[2]));

  // R5
  txload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc.wr && acc.idx == IDX_DATA) |=> $onehot(txLoad));

  // R9
  shared_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc.wr && acc.idx == IDX_VEC)
    |=> (regFile[IDX_VEC*BYTE_W +: BYTE_W] == $past(hostWdata)
         && regFile[(REGS + IDX_VEC)*BYTE_W +: BYTE_W] == $past(hostWdata)));
endmodule

// File: rtl/dual_chan_regport.sv
module dual_chan_regport
  import regport_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         hostChan,
  input  logic                         hostData,
  input  logic                         hostWr,
  input  logic                         hostRd,
  input  logic [7:0]                   hostWdata,
  output logic [7:0]                   hostRdata,
  input  logic [15:0]                  statusIn,
  input  logic [15:0]                  specialIn,
  input  logic [15:0]                  loopStatIn,
  input  logic [15:0]                  rxByteIn,
  input  logic [5:0]                   pendIn,
  output logic [1:0]                   rxPop,
  output logic [1:0]                   txLoad,
  output logic [255:0]                 regFile
);
  accStrobe_t acc;

  regport_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostChan (hostChan),
    .hostData (hostData),
    .hostWr   (hostWr),
    .hostRd   (hostRd),
    .cmdBits  (hostWdata[5:0]),
    .acc      (acc)
  );

  regport_dp i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .acc        (acc),
    .hostWdata  (hostWdata),
    .statusIn   (statusIn),
    .specialIn  (specialIn),
    .loopStatIn (loopStatIn),
    .rxByteIn   (rxByteIn),
    .pendIn     (pendIn),
    .hostRdata  (hostRdata),
    .rxPop      (rxPop),
    .txLoad     (txLoad),
    .regFile    (regFile)
  );
endmodule

// File: tb/test_dual_chan_regport.sv
`timescale 1ns/1ps
module test_dual_chan_regport;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostChan = 1'b0, hostData = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic [15:0] statusIn = 16'hA55A, specialIn = 16'h3C21, loopStatIn = 16'h9182, rxByteIn = 16'h7713;
  logic [5:0]  pendIn = 6'h2B;
  logic [1:0]  rxPop, txLoad;
  logic [255:0] regFile;
  int checks = 0, fails = 0;
  logic [7:0] rv;
  logic [1:0] popSeen, loadSeen;

  always #5 clk = ~clk;

  dual_chan_regport i_dual_chan_regport (.*);

  function automatic logic [7:0] slot(int ch, int r);
    return regFile[(ch*16 + r)*8 +: 8];
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic access(logic ch, logic dat, logic wr, logic rd, logic [7:0] wd);
    @(negedge clk);
    hostChan = ch; hostData = dat; hostWr = wr; hostRd = rd; hostWdata = wd;
    #1;
    rv = hostRdata; popSeen = rxPop;
    @(posedge clk); #1;
    loadSeen = txLoad;
    hostWr = 1'b0; hostRd = 1'b0;
  endtask

  task automatic cmdW(logic ch, logic [7:0] v); access(ch, 1'b0, 1'b1, 1'b0, v); endtask
  task automatic cmdR(logic ch);                access(ch, 1'b0, 1'b0, 1'b1, 8'h00); endtask

  task automatic tReset();
    chk("R1 slot0/12", slot(0, 12), 8'h00);
    chk("R1 slot1/9", slot(1, 9), 8'h00);
    chk("R1 txLoad", {6'b0, txLoad}, 8'h00);
    chk("R11 idle rdata", hostRdata, 8'h00);
    cmdR(1'b0); chk("R1 idle read A", rv, 8'h5A);
    cmdR(1'b1); chk("R3 idle read B", rv, 8'hA5);
  endtask

  task automatic tTimeConst();
    cmdW(1'b0, 8'h0C); chk("R2 pointer byte in slot0", slot(0, 0), 8'h0C);
    cmdW(1'b0, 8'h34); chk("R6 slot12", slot(0, 12), 8'h34);
    cmdR(1'b0);        chk("R4 idle after write", rv, 8'h5A);
    cmdW(1'b0, 8'h0D); cmdW(1'b0, 8'h12);
    cmdW(1'b0, 8'h0C); cmdR(1'b0); chk("R6 read low", rv, 8'h34);
    cmdW(1'b0, 8'h0D); cmdR(1'b0); chk("R6 read high", rv, 8'h12);
    chk("R3 status unchanged slot", slot(0, 13), 8'h12);
  endtask

  task automatic tCodes();
    cmdW(1'b0, 8'h14); cmdW(1'b0, 8'h66);
    chk("R2 other code no +8 (slot4)", slot(0, 4), 8'h66);
    chk("R2 other code no +8 (slot12)", slot(0, 12), 8'h34);
    cmdW(1'b0, 8'h00); cmdR(1'b0); chk("R2 zero target stays idle", rv, 8'h5A);
    cmdW(1'b0, 8'h0C); cmdR(1'b1); chk("R2 other channel idle", rv, 8'hA5);
    cmdR(1'b0); chk("R2 armed channel kept", rv, 8'h34);
  endtask

  task automatic tResync();
    cmdW(1'b0, 8'h0F); cmdW(1'b0, 8'hFF);
    cmdW(1'b0, 8'h0F); cmdR(1'b0); chk("R8 rr15 mask", rv, 8'hFA);
    cmdW(1'b0, 8'h0F); cmdR(1'b0); cmdR(1'b0); chk("R4 two reads resync", rv, 8'h5A);
  endtask

  task automatic tData();
    access(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R5 data read B", rv, 8'h77); chk("R5 rxPop B", {6'b0, popSeen}, 8'h02);
    access(1'b1, 1'b1, 1'b1, 1'b0, 8'h99);
    chk("R5 txLoad B", {6'b0, loadSeen}, 8'h02); chk("R5 slot8 B", slot(1, 8), 8'h99);
    cmdW(1'b1, 8'h0A); access(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    cmdR(1'b1); chk("R10 rr10 after data access", rv, 8'h91);
    cmdW(1'b0, 8'h08); cmdW(1'b0, 8'h42);
    chk("R5 ptr reg8 txLoad A", {6'b0, loadSeen}, 8'h01); chk("R5 slot8 A", slot(0, 8), 8'h42);
    cmdW(1'b0, 8'h08); cmdR(1'b0);
    chk("R5 ptr reg8 read", rv, 8'h13); chk("R5 ptr reg8 pop", {6'b0, popSeen}, 8'h01);
  endtask

  task automatic tPending();
    cmdW(1'b0, 8'h03); cmdR(1'b0); chk("R7 rr3 channel A", rv, 8'h2B);
    cmdW(1'b1, 8'h03); cmdW(1'b1, 8'h77);
    cmdW(1'b1, 8'h03); cmdR(1'b1); chk("R7 rr3 channel B", rv, 8'h00);
  endtask

  task automatic tShared();
    cmdW(1'b1, 8'h02); cmdW(1'b1, 8'hC3);
    chk("R9 vec slot A", slot(0, 2), 8'hC3); chk("R9 vec slot B", slot(1, 2), 8'hC3);
    cmdW(1'b0, 8'h02); cmdR(1'b0); chk("R9 rr2 via A", rv, 8'hC3);
    cmdW(1'b0, 8'h09); cmdW(1'b0, 8'h3C);
    chk("R9 mctl slot B", slot(1, 9), 8'h3C);
  endtask

  task automatic tZeroRegs();
    cmdW(1'b0, 8'h04); cmdR(1'b0); chk("R10 rr4 zero", rv, 8'h00);
    cmdW(1'b0, 8'h09); cmdR(1'b0); chk("R10 rr9 zero", rv, 8'h00);
    cmdW(1'b1, 8'h01); cmdR(1'b1); chk("R10 rr1 special", rv, 8'h3C);
  endtask

  task automatic tBoth();
    access(1'b0, 1'b0, 1'b1, 1'b1, 8'h0C);
    chk("R11 write wins rdata", rv, 8'h00);
    cmdR(1'b0); chk("R11 write wins armed", rv, 8'h34);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset();
    @(negedge clk); rstN = 1'b1;
    tReset(); tTimeConst(); tCodes(); tResync(); tData();
    tPending(); tShared(); tZeroRegs(); tBoth();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule